// File: doc/BRIEF.md
# Reduced bfloat16 Multiplier with Truncating Two-Stage Pipeline

This block multiplies two 16-bit brain-float values (1 sign bit, 8 exponent bits, 7 fraction bits) and returns a product in the same format. It keeps only a reduced subset of floating-point behaviour so that the logic between registers stays short. The product is always truncated toward zero. Tiny values are flushed to signed zero. A value too large to represent is clamped to the largest finite magnitude. The all-ones exponent has no special meaning on input and never appears on output.

One operand pair can enter on every clock. The first register stage holds the sign, the exponent sum, a zero flag and two partially compressed groups of radix-4 Booth partial products. The second stage adds the two groups, normalises with a one-bit shift, removes the bias, applies the flush or clamp rule and registers the word. A valid bit travels with the data through both stages.

Top module: `bf16_rtz_mul`

## Requirements
- R1: The result sign (bit 15) is the XOR of the operand signs. This holds for zero and clamped results too.
- R2: For normal operands, the result exponent (bits 14:7) is ea + eb − 127, plus 1 when bit 15 of the 16-bit product of the hidden-bit significands is set. The fraction (bits 6:0) is the seven product bits just below the leading one.
- R3: Product bits below the kept fraction are discarded, never rounded up.
- R4: An operand with exponent field 0 (zero or subnormal) gives a result with bits 14:0 equal to 0.
- R5: A biased result exponent of 0 or less gives bits 14:0 equal to 0. A result exponent of exactly 1 is kept. No output has exponent 0 with a nonzero fraction.
- R6: A biased result exponent of 255 or more gives bits 14:0 equal to 0x7F7F, the largest finite magnitude.
- R7: An operand exponent of 255 is used as an ordinary value. No valid output has exponent field 255.
- R8: out_valid is high exactly two clock cycles after in_valid was high, and low otherwise. out_prod in that cycle is the product of the operands that were presented with in_valid.
- R9: While rst_n is low, out_valid and out_prod are 0.
- R10: A new operand pair can be accepted on every cycle, and back-to-back results appear on consecutive cycles.
- R11: The significand product is split across the stage-1 register, as two Booth partial-product groups. Their sum one cycle later equals the full significand product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair is valid this cycle |
| op_a | input | 16 | First bfloat16 operand |
| op_b | input | 16 | Second bfloat16 operand |
| out_valid | output | 1 | out_prod holds a product |
| out_prod | output | 16 | bfloat16 product |

## Verification
Every product is due on the second rising edge after its operands are presented. The bench drives at falling edges and compares each result at the falling edge two cycles after the matching stimulus. The vector walk streams one pair per cycle, so the check for vector i is made in the same step that drives vector i+2. A single-pulse test confirms that out_valid stays low one cycle after the stimulus and again three cycles after it. The checker ties each stage-2 output back to the stage-1 state it came from, exactly one edge earlier.

// File: rtl/bf16_rtz_pkg.sv
package bf16_rtz_pkg;
  localparam int EXP_W     = 8;
  localparam int FRAC_W    = 7;
  localparam int WORD_W    = 1 + EXP_W + FRAC_W;
  localparam int SIG_W     = FRAC_W + 1;
  localparam int PROD_W    = 2 * SIG_W;
  localparam int EXT_W     = EXP_W + 3;
  localparam int BIAS      = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_ONES  = (1 << EXP_W) - 1;
  localparam int NDIG      = SIG_W / 2 + 1;
  localparam int BEXT_W    = 2 * NDIG + 1;

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  exp;
    logic [FRAC_W-1:0] frac;
  } bf16_t;

  // Radix-4 Booth partial product of an unsigned multiplicand, two's complement
  function automatic logic [PROD_W-1:0] booth_pp(input logic [SIG_W-1:0] a,
                                                 input logic [2:0] trip);
    logic [PROD_W-1:0] ax;
    ax = PROD_W'(a);
    case (trip)
      3'b001, 3'b010: booth_pp = ax;
      3'b011:         booth_pp = ax << 1;
      3'b100:         booth_pp = -(ax << 1);
      3'b101, 3'b110: booth_pp = -ax;
      default:        booth_pp = '0;
    endcase
  endfunction

  // Signed unbiased-sum exponent, including the normalisation increment
  function automatic logic signed [EXT_W-1:0] result_exp(input logic [EXP_W:0] esum,
                                                         input logic norm);
    result_exp = $signed({2'b00, esum}) + $signed({{(EXT_W-1){1'b0}}, norm})
               - $signed(EXT_W'(BIAS));
  endfunction

  // Seven fraction bits right below the leading one
  function automatic logic [FRAC_W-1:0] pick_frac(input logic [PROD_W-1:0] p,
                                                  input logic norm);
    pick_frac = norm ? p[PROD_W-2 -: FRAC_W] : p[PROD_W-3 -: FRAC_W];
  endfunction
endpackage

// File: rtl/bf16_rtz_sigmul.sv
module bf16_rtz_sigmul
  import bf16_rtz_pkg::*;
#(
  parameter int SPLIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SIG_W-1:0]  sig_a,
  input  logic [SIG_W-1:0]  sig_b,
  output logic [PROD_W-1:0] prod
);
  logic [BEXT_W-1:0] b_ext;
  logic [PROD_W-1:0] pp [NDIG];
  logic [PROD_W-1:0] grp_lo, grp_hi;
  logic [PROD_W-1:0] grp_lo_q, grp_hi_q;

  assign b_ext = {{(BEXT_W-SIG_W-1){1'b0}}, sig_b, 1'b0};

  for (genvar d = 0; d < NDIG; d++) begin : g_pp
    assign pp[d] = booth_pp(sig_a, b_ext[2*d+2 -: 3]) << (2*d);
  end

  always_comb begin
    grp_lo = '0;
    grp_hi = '0;
    for (int d = 0; d < NDIG; d++) begin
      if (d < SPLIT) grp_lo = grp_lo + pp[d];
      else           grp_hi = grp_hi + pp[d];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp_lo_q <= '0;
      grp_hi_q <= '0;
    end else begin
      grp_lo_q <= grp_lo;
      grp_hi_q <= grp_hi;
    end
  end

  assign prod = grp_lo_q + grp_hi_q;
endmodule

// File: rtl/bf16_rtz_pack.sv
module bf16_rtz_pack
  import bf16_rtz_pkg::*;
(
  input  logic              sign,
  input  logic [EXP_W:0]    esum,
  input  logic              zero_in,
  input  logic [PROD_W-1:0] prod,
  output logic              norm,
  output logic              underflow,
  output logic              overflow,
  output logic [WORD_W-1:0] word
);
  logic signed [EXT_W-1:0] e_full;
  bf16_t res;

  assign norm      = prod[PROD_W-1];
  assign e_full    = result_exp(esum, norm);
  assign underflow = (e_full <= $signed(EXT_W'(0)));
  assign overflow  = (e_full >= $signed(EXT_W'(EXP_ONES)));

  always_comb begin
    res.sign = sign;
    if (zero_in || underflow) begin
      res.exp  = '0;
      res.frac = '0;
    end else if (overflow) begin
      res.exp  = EXP_W'(EXP_ONES - 1);
      res.frac = '1;
    end else begin
      res.exp  = e_full[EXP_W-1:0];
      res.frac = pick_frac(prod, norm);
    end
  end

  assign word = res;
endmodule

// File: rtl/bf16_rtz_mul.sv
module bf16_rtz_mul
  import bf16_rtz_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [15:0]       op_a,
  input  logic [15:0]       op_b,
  output logic              out_valid,
  output logic [15:0]       out_prod
);
  bf16_t a_w, b_w;
  logic [SIG_W-1:0]  sig_a, sig_b;
  logic [EXP_W:0]    esum_w;
  logic              zero_w;

  logic              s1_valid, s1_sign, s1_zero;
  logic [EXP_W:0]    s1_esum;
  logic [PROD_W-1:0] sig_prod;

  logic              pk_norm, pk_underflow, pk_overflow;
  logic [WORD_W-1:0] pk_word;

  assign a_w    = op_a;
  assign b_w    = op_b;
  assign sig_a  = {1'b1, a_w.frac};
  assign sig_b  = {1'b1, b_w.frac};
  assign esum_w = {1'b0, a_w.exp} + {1'b0, b_w.exp};
  assign zero_w = (a_w.exp == '0) || (b_w.exp == '0);

  // Stage 1: operand bookkeeping
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_sign  <= 1'b0;
      s1_zero  <= 1'b0;
      s1_esum  <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_sign  <= a_w.sign ^ b_w.sign;
      s1_zero  <= zero_w;
      s1_esum  <= esum_w;
    end
  end

  // Significand product, registered in the middle of its compression tree
  bf16_rtz_sigmul #(.SPLIT(2)) u_sigmul (
    .clk   (clk),
    .rst_n (rst_n),
    .sig_a (sig_a),
    .sig_b (sig_b),
    .prod  (sig_prod)
  );

  bf16_rtz_pack u_pack (
    .sign      (s1_sign),
    .esum      (s1_esum),
    .zero_in   (s1_zero),
    .prod      (sig_prod),
    .norm      (pk_norm),
    .underflow (pk_underflow),
    .overflow  (pk_overflow),
    .word      (pk_word)
  );

  // Stage 2: result register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_prod  <= '0;
    end else begin
      out_valid <= s1_valid;
      out_prod  <= pk_word;
    end
  end
endmodule

// File: rtl/bf16_rtz_mul_chk.sv
module bf16_rtz_mul_chk
  import bf16_rtz_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              out_valid,
  input logic [15:0]       out_prod,
  input logic              s1_valid,
  input logic              s1_sign,
  input logic              s1_zero,
  input logic              pk_underflow,
  input logic              pk_overflow,
  input logic [SIG_W-1:0]  sig_a,
  input logic [SIG_W-1:0]  sig_b,
  input logic [PROD_W-1:0] sig_prod
);
  logic [PROD_W-1:0] ref_prod;
  assign ref_prod = PROD_W'(sig_a) * PROD_W'(sig_b);

  AST_VALID_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> s1_valid);                                            // R8
  AST_VALID_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> out_valid);                                           // R8
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> !out_valid);                                         // R8
  AST_SIGN_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> out_prod[15] == $past(s1_sign));                      // R1
  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_zero) |=> out_prod[14:0] == '0);                   // R4
  AST_UNDERFLOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && pk_underflow) |=> out_prod[14:0] == '0);              // R5
  AST_NO_SUBNORMAL_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_prod[14:7] == '0) |-> out_prod[6:0] == '0);      // R5
  AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && pk_overflow && !s1_zero) |=> out_prod[14:0] == 15'h7F7F); // R6
  AST_NO_ALL_ONES_EXP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_prod[14:7] != 8'hFF);                            // R7
  AST_SPLIT_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> sig_prod == $past(ref_prod));                         // R11
endmodule

bind bf16_rtz_mul bf16_rtz_mul_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .out_valid    (out_valid),
  .out_prod     (out_prod),
  .s1_valid     (s1_valid),
  .s1_sign      (s1_sign),
  .s1_zero      (s1_zero),
  .pk_underflow (pk_underflow),
  .pk_overflow  (pk_overflow),
  .sig_a        (sig_a),
  .sig_b        (sig_b),
  .sig_prod     (sig_prod)
);

// File: tb/bf16_rtz_mul_tb.sv
`timescale 1ns/1ps
module bf16_rtz_mul_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] op_a = '0, op_b = '0;
  logic        out_valid;
  logic [15:0] out_prod;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  bf16_rtz_mul dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .out_prod(out_prod)
  );

  // {op_a, op_b, expected, requirement id}
  localparam int NV = 18;
  localparam logic [55:0] VEC [NV] = '{
    {16'h3F80, 16'h3F80, 16'h3F80, 8'd2},
    {16'h4000, 16'h4040, 16'h40C0, 8'd2},
    {16'h4040, 16'h4040, 16'h4110, 8'd2},
    {16'hBF80, 16'h4000, 16'hC000, 8'd1},
    {16'hC040, 16'hBF80, 16'h4040, 8'd1},
    {16'h3FC1, 16'h3FC1, 16'h4011, 8'd3},
    {16'h0000, 16'h4040, 16'h0000, 8'd4},
    {16'h8001, 16'h3F80, 16'h8000, 8'd4},
    {16'h0050, 16'hBF80, 16'h8000, 8'd4},
    {16'h0080, 16'h3F00, 16'h0000, 8'd5},
    {16'h8080, 16'h3F00, 16'h8000, 8'd5},
    {16'h0080, 16'h3F80, 16'h0080, 8'd5},
    {16'h7F00, 16'h4000, 16'h7F7F, 8'd6},
    {16'hFF00, 16'h4000, 16'hFF7F, 8'd6},
    {16'h7F7F, 16'h3F80, 16'h7F7F, 8'd6},
    {16'h7F80, 16'h3F00, 16'h7F00, 8'd7},
    {16'h7FC0, 16'h3F00, 16'h7F40, 8'd7},
    {16'hFF80, 16'h7F80, 16'hFF7F, 8'd7}
  };

  function automatic string tag_of(input logic [7:0] id);
    case (id)
      8'd1: tag_of = "R1";
      8'd2: tag_of = "R2";
      8'd3: tag_of = "R3";
      8'd4: tag_of = "R4";
      8'd5: tag_of = "R5";
      8'd6: tag_of = "R6";
      default: tag_of = "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    // R9: reset holds the outputs at zero even with valid stimulus
    op_a = 16'h4040; op_b = 16'h4040; in_valid = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 out_valid in reset", {15'b0, out_valid}, 16'h0);
    check("R9 out_prod in reset", out_prod, 16'h0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 out_valid after reset", {15'b0, out_valid}, 16'h0);

    // Vector walk, one pair per cycle (R10); result i checked while driving i+2
    for (int i = 0; i < NV + 2; i++) begin
      if (i >= 2) begin
        check({tag_of(VEC[i-2][7:0]), " R10 valid"}, {15'b0, out_valid}, 16'h1);
        check(tag_of(VEC[i-2][7:0]), out_prod, VEC[i-2][23:8]);
      end
      if (i < NV) begin
        op_a = VEC[i][55:40]; op_b = VEC[i][39:24]; in_valid = 1'b1;
      end else begin
        in_valid = 1'b0;
      end
      @(negedge clk);
    end

    // R8: single pulse; valid is high on the second cycle only
    repeat (2) @(negedge clk);
    check("R8 idle", {15'b0, out_valid}, 16'h0);
    op_a = 16'h4040; op_b = 16'hC000; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; op_a = 16'h3F80; op_b = 16'h3F80;
    check("R8 one cycle later", {15'b0, out_valid}, 16'h0);
    @(negedge clk);
    check("R8 two cycles later", {15'b0, out_valid}, 16'h1);
    check("R8 data", out_prod, 16'hC0C0);
    @(negedge clk);
    check("R8 three cycles later", {15'b0, out_valid}, 16'h0);

    // R5 / R6 boundaries under a repeated stream
    op_a = 16'h3F80; op_b = 16'h0080; in_valid = 1'b1;
    @(negedge clk);
    op_a = 16'h7F00; op_b = 16'h3FFF;
    @(negedge clk);
    in_valid = 1'b0;
    check("R5 exponent one kept", out_prod, 16'h0080);
    @(negedge clk);
    check("R6 exponent 254 kept", out_prod, 16'h7F7F);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule